// File: doc/BRIEF.md
# Binary Floating-Point Multiplier

This block multiplies two binary floating-point operands and returns their product in the same format. Each operand holds a sign bit, a biased exponent field and a fraction field. A normal operand has an implied leading 1 in front of the fraction. The default widths give the 32-bit single-precision layout: an 8-bit exponent biased by 127 and a 23-bit fraction. Both widths are parameters, so a reduced format can be built for exhaustive checking.

The unit is a two-stage pipeline. In the first stage each operand is classified, the special cases are resolved and the significands are multiplied. In the second stage the raw product is normalized, the exponent is range-checked and the result is packed. A `start` pulse with both operands produces a `done` pulse exactly two clock cycles later, and a new operand pair may be presented on every cycle. Rounding is by truncation. Results that leave the normal range saturate to infinity or flush to zero, and a flag reports which of the two happened.

Top module: `fpm_mult`

## Requirements
- R1: `done` is high in the cycle two clock edges after each cycle in which `start` was high, and low otherwise. Back-to-back operations are accepted. `result`, `ovf` and `unf` keep their values while `done` is low.
- R2: For every result that is not NaN, the sign bit (MSB) of the result is the XOR of the two operand sign bits.
- R3: For two normal operands whose significand product is below 2, the stored result exponent is Ea + Eb − bias, where bias = 2^(EXP_W−1) − 1. The result fraction is the product fraction truncated to FRAC_W bits.
- R4: A significand product of 2 or more is shifted right by one place and its exponent is incremented. A denormal operand (exponent field 0, fraction nonzero) counts as 0.M × 2^(1−bias), and the product is shifted left until its leading 1 reaches the hidden-bit position, lowering the exponent by one per place.
- R5: If either operand is NaN (exponent field all ones, fraction nonzero), or the operands are zero and infinity, the result is the canonical NaN: sign 0, exponent all ones, fraction MSB 1 and all other fraction bits 0.
- R6: Infinity (exponent all ones, fraction 0) times a nonzero operand gives infinity with the XOR sign. Zero (exponent 0, fraction 0) times a finite operand gives zero with the XOR sign. In both cases `ovf` and `unf` are 0.
- R7: If the normalized stored exponent is all ones or greater, the result is infinity with the XOR sign and `ovf` is 1.
- R8: If the normalized stored exponent is 0 or less, the result is zero with the XOR sign and `unf` is 1. The block never returns a denormal result.
- R9: While and after reset, before any operation, `done`, `ovf`, `unf` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Operand pair valid this cycle |
| op_a | input | EXP_W+FRAC_W+1 | First operand |
| op_b | input | EXP_W+FRAC_W+1 | Second operand |
| done | output | 1 | Result valid, two cycles after start |
| result | output | EXP_W+FRAC_W+1 | Packed product |
| ovf | output | 1 | Exponent overflow; result saturated to infinity |
| unf | output | 1 | Exponent underflow; result flushed to zero |

## Verification
Most internal faults show up as a wrong result word on the `done` cycle of the operation that triggers them, two cycles after `start`. Faults that can cause this include a wrong bias, a leading-zero count that is off by one, a misplaced fraction slice or a special-case priority in the wrong order. A stage-valid bit that is stuck or dropped shows up instead as a `done` pulse that is missing or extra, or as outputs that change while `done` is low. The reduced format has a 4-bit exponent and a 3-bit fraction. In that format every operand pair is issued, so each normalization shift, every range boundary and every pairing of special codes is reached.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

   typedef enum logic [2:0] {
      FC_ZERO,
      FC_SUB,
      FC_NORM,
      FC_INF,
      FC_NAN
   } fpm_class_e;

endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
   import fpm_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int WORD_W = EXP_W + FRAC_W + 1,
   localparam int SIG_W  = FRAC_W + 1
) (
   input  logic [WORD_W-1:0] op,
   output fpm_class_e        cls,
   output logic              sign,
   output logic [SIG_W-1:0]  sig,
   output logic [EXP_W-1:0]  exp_eff
);

   logic [EXP_W-1:0]  e_fld;
   logic [FRAC_W-1:0] f_fld;
   logic              e_min, e_max, f_nz;

   assign sign  = op[WORD_W-1];
   assign e_fld = op[WORD_W-2 -: EXP_W];
   assign f_fld = op[FRAC_W-1:0];
   assign e_min = (e_fld == '0);
   assign e_max = (e_fld == '1);
   assign f_nz  = (f_fld != '0);

   always_comb begin
      if (e_max)      cls = f_nz ? FC_NAN : FC_INF;
      else if (e_min) cls = f_nz ? FC_SUB : FC_ZERO;
      else            cls = FC_NORM;
   end

   // denormals carry no hidden one and use the smallest normal exponent
   assign sig     = {~e_min, f_fld};
   assign exp_eff = e_min ? EXP_W'(1) : e_fld;

endmodule

// File: rtl/fpm_sigmul.sv
module fpm_sigmul #(
   parameter int SIG_W     = 24,
   parameter int MUL_STYLE = 0,
   localparam int PROD_W   = 2 * SIG_W
) (
   input  logic [SIG_W-1:0]  a,
   input  logic [SIG_W-1:0]  b,
   output logic [PROD_W-1:0] prod
);

   generate
      if (MUL_STYLE == 0) begin : g_op
         assign prod = PROD_W'(a) * PROD_W'(b);
      end else begin : g_rows
         logic [PROD_W-1:0] acc;
         always_comb begin
            acc = '0;
            for (int r = 0; r < SIG_W; r++) begin
               if (b[r]) acc = acc + (PROD_W'(a) << r);
            end
         end
         assign prod = acc;
      end
   endgenerate

endmodule

// File: rtl/fpm_norm.sv
module fpm_norm #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   parameter int XW     = 16,
   localparam int WORD_W = EXP_W + FRAC_W + 1,
   localparam int PROD_W = 2 * (FRAC_W + 1),
   localparam int LZ_W   = $clog2(PROD_W) + 1
) (
   input  logic [PROD_W-1:0]    prod,
   input  logic signed [XW-1:0] exp_base,
   input  logic                 sign,
   output logic [WORD_W-1:0]    word,
   output logic                 ovf,
   output logic                 unf
);

   localparam logic signed [XW-1:0] X_TOP = XW'((1 << EXP_W) - 1);

   logic [LZ_W-1:0]      lz;
   logic                 hit;
   logic [PROD_W-1:0]    aligned;
   logic signed [XW-1:0] exp_n;
   logic [FRAC_W-1:0]    frac;

   always_comb begin
      lz  = '0;
      hit = 1'b0;
      for (int i = PROD_W - 1; i >= 0; i--) begin
         if (!hit && prod[i]) begin
            lz  = LZ_W'(PROD_W - 1 - i);
            hit = 1'b1;
         end
      end
   end

   assign aligned = prod << lz;
   assign frac    = aligned[PROD_W-2 -: FRAC_W];
   assign exp_n   = exp_base + XW'(1) - XW'(lz);

   assign ovf = ($signed(exp_n) >= X_TOP);
   assign unf = ($signed(exp_n) <= $signed(XW'(0)));

   always_comb begin
      if (ovf)      word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      else if (unf) word = {sign, {(WORD_W-1){1'b0}}};
      else          word = {sign, exp_n[EXP_W-1:0], frac};
   end

endmodule

// File: rtl/fpm_mult.sv
module fpm_mult
   import fpm_pkg::*;
#(
   parameter int EXP_W     = 8,
   parameter int FRAC_W    = 23,
   parameter int MUL_STYLE = 0,
   localparam int WORD_W   = EXP_W + FRAC_W + 1,
   localparam int SIG_W    = FRAC_W + 1,
   localparam int PROD_W   = 2 * SIG_W,
   localparam int XW       = EXP_W + $clog2(PROD_W) + 2,
   localparam int BIAS     = (1 << (EXP_W - 1)) - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   output logic              done,
   output logic [WORD_W-1:0] result,
   output logic              ovf,
   output logic              unf
);

   if (EXP_W < 3 || FRAC_W < 2) begin : g_bad_width
      $error("fpm_mult: EXP_W must be >= 3 and FRAC_W >= 2");
   end
   if (MUL_STYLE != 0 && MUL_STYLE != 1) begin : g_bad_style
      $error("fpm_mult: MUL_STYLE must be 0 or 1");
   end

   localparam logic [WORD_W-1:0] NAN_WORD =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   fpm_class_e       cls_a, cls_b;
   logic             sgn_a, sgn_b, sgn_r;
   logic [SIG_W-1:0] sig_a, sig_b;
   logic [EXP_W-1:0] xe_a, xe_b;

   fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
      .op(op_a), .cls(cls_a), .sign(sgn_a), .sig(sig_a), .exp_eff(xe_a));
   fpm_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
      .op(op_b), .cls(cls_b), .sign(sgn_b), .sig(sig_b), .exp_eff(xe_b));

   logic [PROD_W-1:0] prod;
   fpm_sigmul #(.SIG_W(SIG_W), .MUL_STYLE(MUL_STYLE)) u_mul (
      .a(sig_a), .b(sig_b), .prod(prod));

   assign sgn_r = sgn_a ^ sgn_b;

   // special-case resolution, NaN first
   logic              spec;
   logic [WORD_W-1:0] spec_word;
   logic              any_inf, any_zero;

   assign any_inf  = (cls_a == FC_INF)  || (cls_b == FC_INF);
   assign any_zero = (cls_a == FC_ZERO) || (cls_b == FC_ZERO);

   always_comb begin
      spec      = 1'b1;
      spec_word = NAN_WORD;
      if ((cls_a == FC_NAN) || (cls_b == FC_NAN) || (any_inf && any_zero)) begin
         spec_word = NAN_WORD;
      end else if (any_inf) begin
         spec_word = {sgn_r, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (any_zero) begin
         spec_word = {sgn_r, {(WORD_W-1){1'b0}}};
      end else begin
         spec = 1'b0;
      end
   end

   logic signed [XW-1:0] exp_base;
   assign exp_base = XW'(xe_a) + XW'(xe_b) - XW'(BIAS);

   // stage 1 registers
   logic                 s1_v, s1_spec, s1_sign;
   logic [WORD_W-1:0]    s1_word;
   logic [PROD_W-1:0]    s1_prod;
   logic signed [XW-1:0] s1_exp;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1_v    <= 1'b0;
         s1_spec <= 1'b0;
         s1_sign <= 1'b0;
         s1_word <= '0;
         s1_prod <= '0;
         s1_exp  <= '0;
      end else begin
         s1_v <= start;
         if (start) begin
            s1_spec <= spec;
            s1_sign <= sgn_r;
            s1_word <= spec_word;
            s1_prod <= prod;
            s1_exp  <= exp_base;
         end
      end
   end

   logic [WORD_W-1:0] n_word;
   logic              n_ovf, n_unf;

   fpm_norm #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .XW(XW)) u_norm (
      .prod(s1_prod), .exp_base(s1_exp), .sign(s1_sign),
      .word(n_word), .ovf(n_ovf), .unf(n_unf));

   // stage 2 registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done   <= 1'b0;
         result <= '0;
         ovf    <= 1'b0;
         unf    <= 1'b0;
      end else begin
         done <= s1_v;
         if (s1_v) begin
            result <= s1_spec ? s1_word : n_word;
            ovf    <= !s1_spec && n_ovf;
            unf    <= !s1_spec && n_unf;
         end
      end
   end

endmodule

// File: rtl/fpm_mult_chk.sv
module fpm_mult_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int WORD_W = EXP_W + FRAC_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [WORD_W-1:0] op_a,
   input logic [WORD_W-1:0] op_b,
   input logic              done,
   input logic [WORD_W-1:0] result,
   input logic              ovf,
   input logic              unf
);

   localparam logic [WORD_W-1:0] NAN_WORD =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic              st_d1, st_d2;
   logic [WORD_W-1:0] a_d1, a_d2, b_d1, b_d2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_d1 <= 1'b0; st_d2 <= 1'b0;
         a_d1 <= '0; a_d2 <= '0; b_d1 <= '0; b_d2 <= '0;
      end else begin
         st_d1 <= start; st_d2 <= st_d1;
         a_d1 <= op_a;   a_d2 <= a_d1;
         b_d1 <= op_b;   b_d2 <= b_d1;
      end
   end

   logic a_nan, b_nan, r_nan, r_exp_top, r_frac_z;
   assign a_nan     = (a_d2[WORD_W-2 -: EXP_W] == '1) && (a_d2[FRAC_W-1:0] != '0);
   assign b_nan     = (b_d2[WORD_W-2 -: EXP_W] == '1) && (b_d2[FRAC_W-1:0] != '0);
   assign r_exp_top = (result[WORD_W-2 -: EXP_W] == '1);
   assign r_frac_z  = (result[FRAC_W-1:0] == '0);
   assign r_nan     = r_exp_top && !r_frac_z;

   // R1
   done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done == st_d2);

   // R1
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> ($stable(result) && $stable(ovf) && $stable(unf)));

   // R2
   sign_xor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !r_nan) |-> (result[WORD_W-1] == (a_d2[WORD_W-1] ^ b_d2[WORD_W-1])));

   // R5
   nan_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (a_nan || b_nan)) |-> (result == NAN_WORD));

   // R7
   ovf_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && ovf) |-> (r_exp_top && r_frac_z && !unf));

   // R8
   unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && unf) |-> (result[WORD_W-2:0] == '0));

endmodule

bind fpm_mult fpm_mult_chk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
   .done(done), .result(result), .ovf(ovf), .unf(unf));

// File: tb/sim_fpm_mult.sv
`timescale 1ns/1ps
module sim_fpm_mult;

   localparam int EW = 4;
   localparam int FW = 3;
   localparam int NOPS = 1 << (2 * (EW + FW + 1));
   localparam int NSLOT = 70200;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic [7:0] op_a = '0, op_b = '0;
   logic       done, ovf, unf;
   logic [7:0] result;

   int checks = 0;
   int failures = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   fpm_mult #(.EXP_W(EW), .FRAC_W(FW), .MUL_STYLE(1)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .op_a(op_a), .op_b(op_b),
      .done(done), .result(result), .ovf(ovf), .unf(unf));

   // arithmetic model of the 1/4/3 format, bias 7
   function automatic void ref_mul(input logic [7:0] a, input logic [7:0] b,
                                   output logic [7:0] r, output logic o,
                                   output logic u, output string tag);
      int ea, eb, fa, fb, ma, mb, xa, xb, p, k, st, fr;
      logic s;
      bit na, nb, ia, ib, za, zb;
      ea = int'(a[6:3]); fa = int'(a[2:0]);
      eb = int'(b[6:3]); fb = int'(b[2:0]);
      s  = a[7] ^ b[7];
      na = (ea == 15) && (fa != 0); nb = (eb == 15) && (fb != 0);
      ia = (ea == 15) && (fa == 0); ib = (eb == 15) && (fb == 0);
      za = (ea == 0) && (fa == 0);  zb = (eb == 0) && (fb == 0);
      o = 1'b0; u = 1'b0;
      if (na || nb || (ia && zb) || (za && ib)) begin
         r = 8'h7C; tag = "R5";
      end else if (ia || ib) begin
         r = {s, 7'h78}; tag = "R6";
      end else if (za || zb) begin
         r = {s, 7'h00}; tag = "R6";
      end else begin
         ma = (ea == 0) ? fa : fa + 8;  xa = (ea == 0) ? 1 : ea;
         mb = (eb == 0) ? fb : fb + 8;  xb = (eb == 0) ? 1 : eb;
         p = ma * mb;
         k = 0;
         for (int i = 0; i < 8; i++) if (((p >> i) & 1) == 1) k = i;
         st = xa + xb - 7 - 6 + k;
         fr = (k >= 3) ? ((p >> (k - 3)) & 7) : ((p << (3 - k)) & 7);
         if (st >= 15) begin
            r = {s, 7'h78}; o = 1'b1; tag = "R7";
         end else if (st <= 0) begin
            r = {s, 7'h00}; u = 1'b1; tag = "R8";
         end else begin
            r = {s, st[3:0], fr[2:0]};
            tag = (k == 7 || ea == 0 || eb == 0) ? "R4" : "R3";
         end
      end
   endfunction

   task automatic note(input bit ok, input string req, input logic [10:0] act,
                       input logic [10:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h (done,ovf,unf,result)", req, act, exp);
      end
   endtask

   initial begin
      bit         p1_v, p2_v;
      logic [7:0] p1_r, p2_r, last_r;
      logic       p1_o, p2_o, p1_u, p2_u;
      string      p1_t, p2_t;
      int         op;
      p1_v = 0; p2_v = 0; p1_r = 0; p2_r = 0; p1_o = 0; p2_o = 0;
      p1_u = 0; p2_u = 0; p1_t = ""; p2_t = ""; last_r = 0; op = 0;

      repeat (3) @(negedge clk);
      // R9: outputs cleared during reset
      note(done == 0 && result == 0 && ovf == 0 && unf == 0, "R9",
           {done, ovf, unf, result}, 11'h0);
      rst_n = 1'b1;
      @(negedge clk);
      // R9: still cleared after reset with no operation
      note(done == 0 && result == 0 && ovf == 0 && unf == 0, "R9",
           {done, ovf, unf, result}, 11'h0);

      for (int slot = 0; slot < NSLOT; slot++) begin
         @(negedge clk);
         if (p2_v) begin
            // R2: sign bit is part of every compared word
            note(done == 1 && result == p2_r && ovf == p2_o && unf == p2_u, p2_t,
                 {done, ovf, unf, result}, {1'b1, p2_o, p2_u, p2_r});
            last_r = p2_r;
         end else begin
            // R1: no done without a start, outputs held
            note(done == 0 && result == last_r, "R1",
                 {done, ovf, unf, result}, {1'b0, ovf, unf, last_r});
         end
         p2_v = p1_v; p2_r = p1_r; p2_o = p1_o; p2_u = p1_u; p2_t = p1_t;
         if (op < NOPS && (slot % 16) != 15) begin
            op_a  = op[15:8];
            op_b  = op[7:0];
            start = 1'b1;
            ref_mul(op_a, op_b, p1_r, p1_o, p1_u, p1_t);
            p1_v = 1'b1;
            op++;
         end else begin
            start = 1'b0;
            p1_v  = 1'b0;
         end
      end
      // R1: every operand pair was issued and retired
      note(op == NOPS && !p1_v && !p2_v, "R1", 11'(op), 11'(NOPS));

      if (!finished) begin
         finished = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(4 * 300000);
      if (!finished) begin
         finished = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog R1 actual=hung expected=complete");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule